// File: doc/BRIEF.md
# Three-Level Channel Service Scheduler

This block chooses which of a set of channels gets the execution engine next. Each channel holds a two-bit priority setting. It is off after reset, and the host turns it on by setting it to low, middle or high. A channel asks for service through any of three request lines: one from its own channel hardware, one from microcode and one from the host. The three are ORed together and held in a pending bit until the channel is granted.

When the engine is idle, the scheduler picks one enabled pending channel. It presents the channel as a valid flag plus a channel index. The grant then stays fixed until the engine pulses `slot_done`. A slot can last any number of cycles, and nothing ends it early. Levels take turns in a fixed four-step rotation: high, middle, high, low. A step whose level has nothing pending is skipped. Inside a level, the lowest channel number wins. As a result, a low-priority requester waits at most a bounded number of slots, even while high-priority traffic never stops.

Top module: `svc_sched`

## Requirements
- R1: After reset every channel's priority is off (code 0), no request is pending and `grant_vld` is 0.
- R2: A cycle with `prio_we` high writes `prio_wdata` into the priority of channel `prio_sel` at the clock edge. The codes are 0 off, 1 low, 2 middle, 3 high.
- R3: A request on `req_hw`, `req_mc` or `req_host` sets the channel's pending bit only if the channel is enabled at that edge. A request to an off channel is dropped, and enabling the channel later does not produce a grant.
- R4: A channel whose priority is off is never granted.
- R5: A rotation pointer steps through high, middle, high, low. A decision takes the first step, starting at the pointer, whose level has an eligible channel. The pointer then moves to the step after the one used.
- R6: Within the chosen level, the lowest-numbered eligible channel is granted.
- R7: A pending low-priority channel is granted within four grants, even while a high-priority channel requests continuously.
- R8: While `grant_vld` is 1 and `slot_done` is 0, `grant_vld` and `grant_idx` do not change in the next cycle, whatever requests arrive.
- R9: `slot_done` high during a grant drops `grant_vld` in the next cycle. The following edge may issue a new grant.
- R10: Issuing a grant clears that channel's pending bit. A request for the same channel that arrives during its own slot is latched and served in a later slot.
- R11: When idle, a grant is issued at the first edge at which an eligible pending bit is already set. A request first becomes eligible one edge after it is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| prio_we | input | 1 | Priority write strobe |
| prio_sel | input | $clog2(NUM_CH) | Channel whose priority is written |
| prio_wdata | input | 2 | New priority code: 0 off, 1 low, 2 middle, 3 high |
| req_hw | input | NUM_CH | Service requests from channel hardware |
| req_mc | input | NUM_CH | Service requests from microcode |
| req_host | input | NUM_CH | Service requests from the host |
| slot_done | input | 1 | Single-cycle end-of-thread pulse from the engine |
| grant_vld | output | 1 | A time slot is granted |
| grant_idx | output | $clog2(NUM_CH) | Channel owning the current slot |

## Verification
In the first test, every channel requests while every channel is off. This shows that requests are dropped rather than latched (R3, R4). In the second, five channels at mixed levels all request in the same cycle. The grant order that comes out checks the high-middle-high-low rotation against a plain priority order and checks the low-number tie-break. In the third, one high channel requests without pause while a low channel requests once. This shows that the rotation prevents starvation. In the last directed test, a channel requests again during its own long slot, which separates request latching from dropping and tests slot holding. A long random run then mixes priority rewrites, three-source requests and slot lengths, and compares the grant against the reference model in every cycle.

// File: rtl/svc_sched_pkg.sv
// Shared types and the level rotation table for the channel service scheduler.
// Assumes priority codes are two bits wide, with 0 meaning the channel is off.
package svc_sched_pkg;

    typedef enum logic [1:0] {
        LVL_OFF  = 2'd0,
        LVL_LOW  = 2'd1,
        LVL_MID  = 2'd2,
        LVL_HIGH = 2'd3
    } lvl_e;

    localparam int unsigned SEQ_LEN = 4;
    localparam int unsigned SEQ_W   = 2;

    // Level visited at each step of the rotation: high, middle, high, low.
    function automatic lvl_e lvl_at(input logic [SEQ_W-1:0] pos);
        case (pos)
            2'd0:    return LVL_HIGH;
            2'd1:    return LVL_MID;
            2'd2:    return LVL_HIGH;
            default: return LVL_LOW;
        endcase
    endfunction

endpackage

// File: rtl/svc_prio_regs.sv
// Per-channel priority register file with a single write port.
// Assumes one write per cycle; all channels reset to off.
module svc_prio_regs
    import svc_sched_pkg::*;
#(
    parameter int unsigned NUM_CH = 32,
    localparam int unsigned IDX_W = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  sel,
    input  logic [1:0]        wdata,
    output lvl_e              prio_q [NUM_CH]
);

    // Hold each channel's level; write the selected one.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_CH; i++) begin
            if (!rst_n) begin
                prio_q[i] <= LVL_OFF;
            end else if (we && (sel == IDX_W'(i))) begin
                prio_q[i] <= lvl_e'(wdata);
            end
        end
    end

endmodule

// File: rtl/svc_req_latch.sv
// Latches service requests from three sources into one pending bit per channel.
// Assumes en_vec marks enabled channels; requests to off channels are dropped,
// and a set on the same edge as a clear wins.
module svc_req_latch #(
    parameter int unsigned NUM_CH = 32,
    localparam int unsigned IDX_W = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] req_hw,
    input  logic [NUM_CH-1:0] req_mc,
    input  logic [NUM_CH-1:0] req_host,
    input  logic [NUM_CH-1:0] en_vec,
    input  logic              clr_vld,
    input  logic [IDX_W-1:0]  clr_idx,
    output logic [NUM_CH-1:0] pend_q
);

    logic [NUM_CH-1:0] req_any;
    logic [NUM_CH-1:0] clr_vec;

    // Merge the three request sources.
    always_comb req_any = req_hw | req_mc | req_host;

    // Decode the grant clear into a one-hot mask.
    always_comb begin
        clr_vec = '0;
        if (clr_vld) clr_vec[clr_idx] = 1'b1;
    end

    // Update pending bits: keep uncleared ones, add new ones, drop off channels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= en_vec & ((pend_q & ~clr_vec) | req_any);
        end
    end

    p_drop_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_q & ~$past(en_vec)) == '0));

    p_clear_on_grant_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_vld && !req_any[clr_idx]) |=> !pend_q[$past(clr_idx)]);

    p_latch_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_any[clr_idx] && en_vec[clr_idx]) |=> pend_q[$past(clr_idx)]);

endmodule

// File: rtl/svc_lowest_pick.sv
// Finds the lowest-numbered set bit of a vector.
// Purely combinational; hit is low when the vector is empty.
module svc_lowest_pick #(
    parameter int unsigned NUM_CH = 32,
    localparam int unsigned IDX_W = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] vec,
    output logic              hit,
    output logic [IDX_W-1:0]  idx
);

    // Scan from the top down so the lowest set bit is written last.
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (vec[i]) begin
                hit = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end

    p_pick_lowest_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (vec[idx] && ((vec & ((NUM_CH'(1) << idx) - NUM_CH'(1))) == '0)));

endmodule

// File: rtl/svc_sched.sv
// Channel service scheduler: selects one eligible pending channel per slot using
// a high-middle-high-low level rotation and a low-number tie-break, then holds
// the grant until the engine pulses slot_done.
// Assumes slot_done is a single-cycle pulse given only while a grant is held.
module svc_sched
    import svc_sched_pkg::*;
#(
    parameter int unsigned NUM_CH = 32,
    localparam int unsigned IDX_W = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prio_we,
    input  logic [IDX_W-1:0]  prio_sel,
    input  logic [1:0]        prio_wdata,
    input  logic [NUM_CH-1:0] req_hw,
    input  logic [NUM_CH-1:0] req_mc,
    input  logic [NUM_CH-1:0] req_host,
    input  logic              slot_done,
    output logic              grant_vld,
    output logic [IDX_W-1:0]  grant_idx
);

    lvl_e              prio_q [NUM_CH];
    logic [NUM_CH-1:0] en_vec;
    logic [NUM_CH-1:0] pend_q;
    logic [NUM_CH-1:0] elig_vec;
    logic [NUM_CH-1:0] lvl_vec [4];
    logic              lvl_hit [4];
    logic [IDX_W-1:0]  lvl_idx [4];
    logic [SEQ_W-1:0]  seq_q;
    logic              pick_found;
    logic [SEQ_W-1:0]  pick_pos;
    logic [IDX_W-1:0]  pick_idx;
    logic              issue;

    svc_prio_regs #(.NUM_CH(NUM_CH)) u_prio (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (prio_we),
        .sel    (prio_sel),
        .wdata  (prio_wdata),
        .prio_q (prio_q)
    );

    // Build enable and per-level eligibility masks.
    always_comb begin
        for (int i = 0; i < NUM_CH; i++) begin
            en_vec[i] = (prio_q[i] != LVL_OFF);
        end
        elig_vec = pend_q & en_vec;
    end

    svc_req_latch #(.NUM_CH(NUM_CH)) u_req (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_hw   (req_hw),
        .req_mc   (req_mc),
        .req_host (req_host),
        .en_vec   (en_vec),
        .clr_vld  (issue),
        .clr_idx  (pick_idx),
        .pend_q   (pend_q)
    );

    // Level 0 (off) has no candidates by definition.
    always_comb begin
        lvl_vec[0] = '0;
        lvl_hit[0] = 1'b0;
        lvl_idx[0] = '0;
    end

    for (genvar l = 1; l < 4; l++) begin : g_lvl
        // Select pending channels sitting at this level.
        always_comb begin
            for (int i = 0; i < NUM_CH; i++) begin
                lvl_vec[l][i] = pend_q[i] && (prio_q[i] == lvl_e'(l));
            end
        end

        svc_lowest_pick #(.NUM_CH(NUM_CH)) u_pick (
            .clk   (clk),
            .rst_n (rst_n),
            .vec   (lvl_vec[l]),
            .hit   (lvl_hit[l]),
            .idx   (lvl_idx[l])
        );
    end

    // Walk the rotation from the pointer and take the first step with a candidate.
    always_comb begin
        pick_found = 1'b0;
        pick_pos   = seq_q;
        pick_idx   = '0;
        for (int k = 0; k < SEQ_LEN; k++) begin
            logic [SEQ_W-1:0] pos;
            pos = seq_q + SEQ_W'(k);
            if (!pick_found && lvl_hit[lvl_at(pos)]) begin
                pick_found = 1'b1;
                pick_pos   = pos;
                pick_idx   = lvl_idx[lvl_at(pos)];
            end
        end
    end

    // A decision is made only when no slot is held.
    always_comb issue = !grant_vld && pick_found;

    // Grant register and rotation pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_vld <= 1'b0;
            grant_idx <= '0;
            seq_q     <= '0;
        end else if (issue) begin
            grant_vld <= 1'b1;
            grant_idx <= pick_idx;
            seq_q     <= pick_pos + SEQ_W'(1);
        end else if (grant_vld && slot_done) begin
            grant_vld <= 1'b0;
        end
    end

    p_hold_slot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_vld && !slot_done) |=> (grant_vld && $stable(grant_idx)));

    p_done_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_vld && slot_done) |=> !grant_vld);

    p_grant_enabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant_vld) |-> (($past(elig_vec) & (NUM_CH'(1) << grant_idx)) != '0));

    p_idle_no_grant_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!grant_vld && (elig_vec == '0)) |=> !grant_vld);

    p_idle_grants_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!grant_vld && (elig_vec != '0)) |=> grant_vld);

endmodule

// File: tb/svc_sched_tb_top.sv
// Bench for svc_sched: a behavioural reference model stepped on every clock and
// compared against the design's grant outputs, plus directed scenarios.
module svc_sched_tb_top;

    localparam int NCH = 32;
    localparam int IW  = $clog2(NCH);

    logic           clk = 1'b0;
    logic           rst_n;
    logic           prio_we;
    logic [IW-1:0]  prio_sel;
    logic [1:0]     prio_wdata;
    logic [NCH-1:0] req_hw, req_mc, req_host;
    logic           slot_done;
    logic           grant_vld;
    logic [IW-1:0]  grant_idx;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // Reference model state.
    int m_prio [NCH];
    bit m_pend [NCH];
    int m_sp;
    bit m_gv;
    int m_gidx;
    int glog [$];

    // Slot length control.
    int slot_len = 1;
    int slot_cnt = 0;
    bit rand_len = 0;

    always #4 clk = ~clk;

    svc_sched #(.NUM_CH(NCH)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .prio_we    (prio_we),
        .prio_sel   (prio_sel),
        .prio_wdata (prio_wdata),
        .req_hw     (req_hw),
        .req_mc     (req_mc),
        .req_host   (req_host),
        .slot_done  (slot_done),
        .grant_vld  (grant_vld),
        .grant_idx  (grant_idx)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int seq_lvl(input int pos);
        if (pos == 0 || pos == 2) return 3;
        if (pos == 1) return 2;
        return 1;
    endfunction

    // Advance the model by one clock edge using the inputs the design saw.
    task automatic model_step();
        bit issued = 0;
        int gi = 0;
        if (!rst_n) begin
            foreach (m_prio[i]) begin m_prio[i] = 0; m_pend[i] = 0; end
            m_sp = 0; m_gv = 0; m_gidx = 0;
            return;
        end
        if (!m_gv) begin
            for (int k = 0; k < 4 && !issued; k++) begin
                int pos = (m_sp + k) % 4;
                for (int i = 0; i < NCH && !issued; i++) begin
                    if (m_pend[i] && m_prio[i] == seq_lvl(pos)) begin
                        issued = 1; gi = i; m_sp = (pos + 1) % 4;
                    end
                end
            end
        end
        for (int i = 0; i < NCH; i++) begin
            bit r = req_hw[i] | req_mc[i] | req_host[i];
            bit keep = m_pend[i] && !(issued && gi == i);
            m_pend[i] = (m_prio[i] != 0) && (keep || r);
        end
        if (issued) begin
            m_gv = 1; m_gidx = gi; glog.push_back(gi);
        end else if (m_gv && slot_done) begin
            m_gv = 0;
        end
        if (prio_we) m_prio[prio_sel] = prio_wdata;
    endtask

    // One clock: model update after the edge, compare and drive at the falling edge.
    task automatic tick();
        @(posedge clk);
        #1 model_step();
        @(negedge clk);
        check("R8 R9 per-cycle grant_vld", grant_vld, m_gv);
        if (m_gv) check("R5 R6 per-cycle grant_idx", grant_idx, m_gidx);
        prio_we = 0; req_hw = '0; req_mc = '0; req_host = '0; slot_done = 0;
        if (grant_vld) begin
            slot_cnt++;
            if (slot_cnt >= slot_len) begin
                slot_done = 1;
                slot_cnt = 0;
                if (rand_len) slot_len = 1 + $urandom_range(0, 4);
            end
        end else begin
            slot_cnt = 0;
        end
    endtask

    task automatic setp(input int ch, input int lv);
        prio_we = 1; prio_sel = IW'(ch); prio_wdata = 2'(lv);
        tick();
    endtask

    task automatic drain();
        for (int n = 0; n < 200; n++) begin
            bit any = 0;
            foreach (m_pend[i]) if (m_pend[i] && m_prio[i] != 0) any = 1;
            if (!any && !m_gv) break;
            tick();
        end
    endtask

    task automatic clear_prios();
        for (int i = 0; i < NCH; i++) if (m_prio[i] != 0) setp(i, 0);
    endtask

    initial begin
        rst_n = 0; prio_we = 0; prio_sel = '0; prio_wdata = '0;
        req_hw = '0; req_mc = '0; req_host = '0; slot_done = 0;
        repeat (3) tick();
        rst_n = 1;
        check("R1 grant_vld after reset", grant_vld, 0);

        // R3 / R4: requests to off channels are dropped and never granted.
        for (int n = 0; n < 3; n++) begin
            req_hw = '1; req_mc = '1; req_host = '1;
            tick();
        end
        check("R4 no grant while all off", grant_vld, 0);
        setp(3, 1);
        repeat (4) tick();
        check("R3 dropped request not granted after enable", grant_vld, 0);
        setp(3, 0);

        // R5 / R6: mixed levels requested together.
        setp(5, 3); setp(9, 3); setp(2, 2); setp(7, 1); setp(1, 1);
        glog.delete();
        slot_len = 2;
        req_hw[5] = 1; req_mc[9] = 1; req_host[2] = 1; req_hw[7] = 1; req_mc[1] = 1;
        tick();
        check("R11 no grant on request edge", grant_vld, 0);
        tick();
        check("R11 grant on following edge", grant_vld, 1);
        drain();
        check("R5 grant count", glog.size(), 5);
        if (glog.size() == 5) begin
            check("R5 first grant high", glog[0], 5);
            check("R5 second grant middle", glog[1], 2);
            check("R5 third grant high", glog[2], 9);
            check("R6 fourth grant lowest low", glog[3], 1);
            check("R6 fifth grant remaining low", glog[4], 7);
        end
        clear_prios();

        // R7: low channel served while a high channel requests without pause.
        setp(5, 3); setp(7, 1);
        glog.delete();
        slot_len = 1;
        req_host[7] = 1;
        for (int n = 0; n < 30; n++) begin
            req_hw[5] = 1;
            tick();
        end
        begin
            int pos7 = -1;
            foreach (glog[i]) if (glog[i] == 7 && pos7 < 0) pos7 = i;
            check("R7 low channel granted", (pos7 >= 0) ? 1 : 0, 1);
            check("R7 low within four grants", (pos7 >= 0 && pos7 < 4) ? 1 : 0, 1);
        end
        drain();
        clear_prios();

        // R8 / R10: long slot, same channel re-requests during its own slot.
        setp(9, 2);
        glog.delete();
        slot_len = 20;
        req_mc[9] = 1;
        tick(); tick();
        check("R8 slot started", grant_vld, 1);
        for (int n = 0; n < 5; n++) tick();
        req_host[9] = 1; req_hw[4] = 1;
        tick();
        for (int n = 0; n < 5; n++) tick();
        check("R8 grant still held", grant_vld, 1);
        check("R8 grant index held", grant_idx, 9);
        slot_len = 1;
        drain();
        check("R10 re-request served again", glog.size(), 2);
        clear_prios();

        // R2 and broad coverage: random priority rewrites, requests and slot lengths.
        rand_len = 1;
        for (int n = 0; n < 4000; n++) begin
            if ($urandom_range(0, 9) == 0) begin
                prio_we = 1;
                prio_sel = IW'($urandom_range(0, NCH - 1));
                prio_wdata = 2'($urandom_range(0, 3));
            end
            if ($urandom_range(0, 2) == 0) begin
                req_hw[$urandom_range(0, NCH - 1)] = 1;
                req_mc[$urandom_range(0, NCH - 1)] = 1;
                req_host[$urandom_range(0, NCH - 1)] = 1;
            end
            tick();
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run is counted as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule